// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block serialises bytes into asynchronous frames on a single transmit line. Software-side logic writes characters into a 16-entry transmit queue through a write strobe. A framing engine takes them out one at a time and sends a low start bit, the data bits least significant first, an optional parity bit and one or two stop bits. Every bit lasts one interval of an externally supplied single-cycle baud tick.

A 10-bit mode word selects the character length, the parity type and the stop-bit count, and can loop the transmit line back onto the receive path. A 9-bit command word enables or disables the transmitter, flushes and aborts it, and starts or ends a break. A break holds the line low. After a break ends, the line is guaranteed a full frame of idle time before the next character goes out.

Top module: `uart_frame_tx`

## Requirements
- R1: A frame starts with one low start bit, followed by the data bits sent least significant bit first. Mode bits [2:1] set the character length: 00 gives 8 bits, 10 gives 7 bits, 11 gives 6 bits, and 01 is treated as 8. Unused high data bits are not sent.
- R2: Mode bits [5:3] set the parity bit that follows the data. 000 gives even parity, 001 odd, 010 a constant 0, and 011 a constant 1. Any code with bit 5 set sends no parity bit. Even and odd parity are computed over the configured data bits only.
- R3: Mode bit 7 set sends two high stop bits. Mode bit 7 clear sends one.
- R4: A mode write made while a frame is in progress does not change that frame. The new format applies from the next frame.
- R5: Command bit 4 enables the transmitter and command bit 5 disables it. When both are set, the transmitter ends up disabled. A frame already in progress when the disable arrives is completed. While the transmitter is disabled, queued characters stay in the queue.
- R6: Command bit 7 starts a break. The transmit line goes low on the cycle after the command and stays low. A frame in progress is dropped, and no character is taken from the queue during the break. Command bit 8 ends a break and takes priority over bit 7.
- R7: After a break ends, the line stays high for exactly one frame length F of the current mode (F = 1 + data + parity + stop bits) in baud ticks. The next start bit is driven on baud tick F+1.
- R8: Command bit 1 empties the queue and aborts any frame or guard time in progress. On the next cycle the line is high and the empty flag is set.
- R9: The queue holds 16 characters and sends them in write order. The full flag is set when 16 characters are held, and a write while full is dropped. The empty flag is set when no characters are held.
- R10: When mode bits [9:8] are 10, the receive-path output carries the transmit line. For any other value of those bits, it carries the external receive input.
- R11: The line only changes on a baud tick, apart from commands and breaks. Queued characters are sent back to back, with the next start bit directly after the last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| baud_tick_i | input | 1 | One-cycle pulse marking each bit interval |
| mode_wr_i | input | 1 | Mode word write strobe |
| mode_i | input | 10 | Mode word |
| ctrl_wr_i | input | 1 | Command word write strobe |
| ctrl_i | input | 9 | Command word |
| data_wr_i | input | 1 | Character write strobe |
| data_i | input | 8 | Character to queue |
| rxd_i | input | 1 | External receive line |
| txd_o | output | 1 | Transmit line, idle high |
| rx_o | output | 1 | Receive-path input (loopback-selected) |
| tx_full_o | output | 1 | Queue full |
| tx_empty_o | output | 1 | Queue empty |

## Verification
Several properties are checked on every cycle. The queue is never popped while empty and its occupancy never exceeds its depth. A start bit is always low, and no character is taken during a break. The line moves only on a tick or a command. A disable always wins over an enable, and a flush leaves the queue empty.

Other behaviour is only visible in the directed scenarios. These cover the exact bit order and parity value for each format, and a mode change landing mid-frame. They also cover the length of the guard time after a break, the in-order drain of a full queue with a dropped extra write, and loopback selection.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MODE_W = 10;
  localparam int CTRL_W = 9;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 4;
  localparam int FLEN_W = 5;

  localparam int CMD_RST     = 1;
  localparam int CMD_EN      = 4;
  localparam int CMD_DIS     = 5;
  localparam int CMD_BRK_ON  = 7;
  localparam int CMD_BRK_OFF = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_GUARD
  } tx_state_e;

  function automatic logic [LEN_W-1:0] char_bits(input logic [MODE_W-1:0] m);
    case (m[2:1])
      2'b10:   char_bits = 4'd7;
      2'b11:   char_bits = 4'd6;
      default: char_bits = 4'd8;
    endcase
  endfunction

  function automatic logic par_on(input logic [MODE_W-1:0] m);
    par_on = !m[5];
  endfunction

  function automatic logic two_stop(input logic [MODE_W-1:0] m);
    two_stop = m[7];
  endfunction

  function automatic logic loop_on(input logic [MODE_W-1:0] m);
    loop_on = (m[9:8] == 2'b10);
  endfunction

  function automatic logic [FLEN_W-1:0] frame_bits(input logic [MODE_W-1:0] m);
    frame_bits = 5'd2 + {1'b0, char_bits(m)} + {4'd0, par_on(m)} + {4'd0, two_stop(m)};
  endfunction

  function automatic logic par_bit(input logic [MODE_W-1:0] m, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] mask;
    logic x;
    mask = 8'hFF >> (4'd8 - char_bits(m));
    x = ^(d & mask);
    case (m[4:3])
      2'b00:   par_bit = x;
      2'b01:   par_bit = ~x;
      2'b10:   par_bit = 1'b0;
      default: par_bit = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wptr_q] <= wdata_i;
  end

  p_pop_nonempty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_count_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_full_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o);
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              brk_i,
  input  logic              brk_end_i,
  input  logic              abort_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pop_o,
  output logic              line_o
);
  tx_state_e         state_q;
  logic [DATA_W-1:0] sh_q;
  logic [LEN_W-1:0]  cnt_q, len_q;
  logic              par_en_q, par_q, two_q, stop2_q, line_q;
  logic [FLEN_W-1:0] gcnt_q;
  logic              slot, hold;

  // a new frame may begin in this tick slot
  assign slot = (state_q == ST_IDLE)
             || (state_q == ST_STOP && (!two_q || stop2_q))
             || (state_q == ST_GUARD && gcnt_q == 5'd1);
  assign hold   = abort_i || brk_end_i || brk_i;
  assign pop_o  = tick_i && !hold && slot && en_i && avail_i;
  assign line_o = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sh_q     <= '0;
      cnt_q    <= '0;
      len_q    <= 4'd8;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
      two_q    <= 1'b0;
      stop2_q  <= 1'b0;
      gcnt_q   <= '0;
      line_q   <= 1'b1;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      line_q  <= 1'b1;
    end else if (brk_end_i) begin
      state_q <= ST_GUARD;
      gcnt_q  <= frame_bits(mode_i) + 5'd1;
      line_q  <= 1'b1;
    end else if (brk_i) begin
      state_q <= ST_IDLE;
      line_q  <= 1'b1;
    end else if (tick_i) begin
      if (pop_o) begin
        sh_q     <= data_i;
        len_q    <= char_bits(mode_i);
        par_en_q <= par_on(mode_i);
        par_q    <= par_bit(mode_i, data_i);
        two_q    <= two_stop(mode_i);
        line_q   <= 1'b0;
        state_q  <= ST_START;
      end else if (slot) begin
        state_q <= ST_IDLE;
        line_q  <= 1'b1;
      end else begin
        case (state_q)
          ST_START: begin
            line_q  <= sh_q[0];
            sh_q    <= sh_q >> 1;
            cnt_q   <= 4'd1;
            state_q <= ST_DATA;
          end
          ST_DATA: begin
            if (cnt_q == len_q) begin
              stop2_q <= 1'b0;
              if (par_en_q) begin
                line_q  <= par_q;
                state_q <= ST_PAR;
              end else begin
                line_q  <= 1'b1;
                state_q <= ST_STOP;
              end
            end else begin
              line_q <= sh_q[0];
              sh_q   <= sh_q >> 1;
              cnt_q  <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            line_q  <= 1'b1;
            state_q <= ST_STOP;
          end
          ST_STOP:  stop2_q <= 1'b1;
          ST_GUARD: gcnt_q  <= gcnt_q - 1'b1;
          default:  state_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_start_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !line_o);
  p_no_pop_in_brk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !pop_o);
  p_tick_paced_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> $past(tick_i) || $past(abort_i) || $past(brk_i) || $past(brk_end_i));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              rx_o,
  output logic              tx_full_o,
  output logic              tx_empty_o
);
  logic [MODE_W-1:0] mode_q;
  logic              en_q, brk_q;
  logic              tx_rst, brk_end, pop, line;
  logic [DATA_W-1:0] head;
  logic              ctrl_unused;

  assign ctrl_unused = ^{ctrl_i[0], ctrl_i[3:2], ctrl_i[6]};
  assign tx_rst  = ctrl_wr_i && ctrl_i[CMD_RST];
  assign brk_end = ctrl_wr_i && ctrl_i[CMD_BRK_OFF] && brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      if (mode_wr_i) mode_q <= mode_i;
      if (ctrl_wr_i) begin
        if (ctrl_i[CMD_DIS])     en_q <= 1'b0;
        else if (ctrl_i[CMD_EN]) en_q <= 1'b1;
        if (ctrl_i[CMD_BRK_OFF])     brk_q <= 1'b0;
        else if (ctrl_i[CMD_BRK_ON]) brk_q <= 1'b1;
      end
    end
  end

  uart_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_rst),
    .push_i  (data_wr_i),
    .wdata_i (data_i),
    .pop_i   (pop),
    .rdata_o (head),
    .full_o  (tx_full_o),
    .empty_o (tx_empty_o)
  );

  uart_tx_framer u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (baud_tick_i),
    .en_i      (en_q),
    .brk_i     (brk_q),
    .brk_end_i (brk_end),
    .abort_i   (tx_rst),
    .mode_i    (mode_q),
    .avail_i   (!tx_empty_o),
    .data_i    (head),
    .pop_o     (pop),
    .line_o    (line)
  );

  assign txd_o = brk_q ? 1'b0 : line;
  assign rx_o  = loop_on(mode_q) ? txd_o : rxd_i;

  p_dis_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_i[CMD_DIS] |=> !en_q);
  p_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rst |=> tx_empty_o && txd_o == !brk_q);
  p_brk_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_i[CMD_BRK_ON] && !ctrl_i[CMD_BRK_OFF] |=> !txd_o);
endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       mode_wr = 1'b0;
  logic [9:0] mode = '0;
  logic       ctrl_wr = 1'b0;
  logic [8:0] ctrl = '0;
  logic       data_wr = 1'b0;
  logic [7:0] data = '0;
  logic       rxd = 1'b1;
  logic       txd, rx, full, empty;
  logic       smp;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  uart_frame_tx u_uart_frame_tx (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick),
    .mode_wr_i(mode_wr), .mode_i(mode), .ctrl_wr_i(ctrl_wr), .ctrl_i(ctrl),
    .data_wr_i(data_wr), .data_i(data), .rxd_i(rxd),
    .txd_o(txd), .rx_o(rx), .tx_full_o(full), .tx_empty_o(empty)
  );

  // mode, char, expected bits after start (first bit in bit 0), count
  typedef struct packed {
    logic [9:0]  m;
    logic [7:0]  d;
    logic [11:0] e;
    logic [3:0]  n;
  } vec_t;
  localparam vec_t VEC [8] = '{
    '{10'h020, 8'hA5, 12'h1A5, 4'd9},   // 8N1
    '{10'h004, 8'h53, 12'h153, 4'd9},   // 7E1
    '{10'h08E, 8'hFF, 12'h1FF, 4'd9},   // 6O2
    '{10'h018, 8'h00, 12'h300, 4'd10},  // 8 mark
    '{10'h010, 8'hFF, 12'h2FF, 4'd10},  // 8 space
    '{10'h008, 8'h01, 12'h201, 4'd10},  // 8O1
    '{10'h00C, 8'h80, 12'h180, 4'd9},   // 7O1, bit 7 excluded
    '{10'h000, 8'h80, 12'h380, 4'd10}   // 8E1
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; smp = txd;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [8:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_mode(input logic [9:0] v);
    @(negedge clk); mode_wr = 1'b1; mode = v;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk); data_wr = 1'b1; data = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic wait_start(output int idle);
    idle = 0;
    do_tick();
    while (smp && idle < 40) begin
      idle++;
      do_tick();
    end
  endtask

  task automatic get_bits(input int n, output logic [11:0] b);
    b = '0;
    for (int i = 0; i < n; i++) begin
      do_tick();
      b[i] = smp;
    end
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      do_tick();
      if (smp) h++;
    end
  endtask

  initial begin
    int idle;
    int h;
    logic [11:0] b;
    logic [11:0] m;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && empty && !full, "R9 reset state", {txd, empty, full}, 3'b110);

    // format table, R1 R2 R3
    wr_ctrl(9'h010);
    for (int k = 0; k < 8; k++) begin
      wr_mode(VEC[k].m);
      push(VEC[k].d);
      wait_start(idle);
      get_bits(int'(VEC[k].n), b);
      m = 12'hFFF >> (12 - int'(VEC[k].n));
      chk((b & m) == VEC[k].e, "R1/R2/R3 frame format", b & m, VEC[k].e);
    end

    // R4: mode write mid-frame keeps current format
    wr_mode(10'h020);
    push(8'h00);
    wait_start(idle);
    wr_mode(10'h08E);
    get_bits(9, b);
    chk(b[8:0] == 9'h100, "R4 frame keeps format", b, 12'h100);
    push(8'hFF);
    wait_start(idle);
    get_bits(9, b);
    chk(b[8:0] == 9'h1FF, "R4 next frame new format", b, 12'h1FF);

    // R5: disable mid-frame completes, queued char held, disable wins
    wr_mode(10'h020);
    push(8'h5A);
    wait_start(idle);
    wr_ctrl(9'h020);
    get_bits(9, b);
    chk(b[8:0] == 9'h15A, "R5 frame completes after disable", b, 12'h15A);
    push(8'h11);
    count_high(15, h);
    chk(h == 15 && !empty, "R5 disabled holds queue", h, 15);
    wr_ctrl(9'h030);
    count_high(12, h);
    chk(h == 12 && !empty, "R5 disable beats enable", h, 12);
    wr_ctrl(9'h010);
    wait_start(idle);
    get_bits(9, b);
    chk(b[8:0] == 9'h111, "R5 resume after enable", b, 12'h111);

    // R9 R11: fill, drop extra, drain in order back to back
    wr_ctrl(9'h020);
    for (int i = 0; i < 16; i++) push(8'((i * 17 + 3) & 8'hFF));
    chk(full && !empty, "R9 full after 16", {full, empty}, 2'b10);
    push(8'hEE);
    wr_ctrl(9'h010);
    for (int i = 0; i < 16; i++) begin
      v = 8'((i * 17 + 3) & 8'hFF);
      wait_start(idle);
      if (i > 0) chk(idle == 0, "R11 back-to-back frames", idle, 0);
      get_bits(9, b);
      chk(b[8:0] == {1'b1, v}, "R9 order kept", b, {1'b1, v});
    end
    count_high(12, h);
    chk(h == 12 && empty, "R9 extra write dropped", h, 12);

    // R6 R7: break
    wr_ctrl(9'h090);
    push(8'h3C);
    chk(txd == 1'b0, "R6 break drives low", txd, 0);
    count_high(5, h);
    chk(h == 0 && !empty, "R6 break holds, no char taken", h, 0);
    wr_ctrl(9'h100);
    chk(txd == 1'b1, "R6 break stop idles high", txd, 1);
    wait_start(idle);
    chk(idle == 10, "R7 guard one frame time", idle, 10);
    get_bits(9, b);
    chk(b[8:0] == 9'h13C, "R7 char after guard", b, 12'h13C);
    wr_ctrl(9'h180);
    chk(txd == 1'b1, "R6 stop wins over start", txd, 1);

    // R8: transmit reset
    push(8'hAA);
    push(8'hBB);
    wait_start(idle);
    do_tick(); do_tick(); do_tick();
    wr_ctrl(9'h002);
    chk(txd == 1'b1 && empty, "R8 reset flushes and idles", {txd, empty}, 2'b11);
    count_high(12, h);
    chk(h == 12, "R8 no frame after reset", h, 12);

    // R10: loopback
    rxd = 1'b0;
    wr_mode(10'h020);
    chk(rx == 1'b0, "R10 normal passes rxd", rx, 0);
    wr_mode(10'h220);
    chk(rx == 1'b1, "R10 loopback idle high", rx, 1);
    rxd = 1'b1;
    wr_ctrl(9'h080);
    chk(rx == 1'b0, "R10 loopback follows break", rx, 0);
    wr_ctrl(9'h100);
    wr_mode(10'h020);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule